// File: doc/BRIEF.md
# Parallel Link Counting-Pattern Error Checker

This block sits behind a deserialised 28-bit parallel link and judges the link's bit-error behaviour during bring-up and soak testing. The far end sends one word per link clock. Each word carries the same wrapping 8-bit count in three byte lanes. The count steps by one per word. The checker takes the first valid word after reset or clear as its starting point. From then on it predicts every following word and fires a one-cycle trigger on any word that differs from the prediction. It keeps a saturating count of erroneous words and a saturating count of all words seen, so a long run can be read out as an error ratio.

When a word is wrong, the checker chooses its next prediction by majority vote across the three lanes. A single damaged lane therefore does not knock it off the sequence. A true jump of the whole stream re-aligns it after one reported error. A small pattern generator that emits the matching stream is provided for the transmit side and for test.

Top module: `lnk_err_chk`

## Requirements
- R1: A correct word carries the count in bits 7:0, 15:8 and 23:16, and has bits 27:24 at zero. A difference in any lane or any nonzero top bit makes the word erroneous.
- R2: The first valid word after reset or clear is never flagged. Its bits 7:0 seed the expectation, and the next word is expected to carry that value plus one.
- R3: For every valid word, the expected count advances by one, and 255 is followed by 0.
- R4: A word presented with `rx_valid` low is not compared, is not counted and does not advance the expectation.
- R5: For each erroneous valid word, `err_pulse` is high for exactly the one cycle after the edge that samples that word.
- R6: `err_count` increments once per erroneous word and holds at all ones instead of wrapping.
- R7: `word_count` increments once per valid word, including the seeding word, and holds at all ones instead of wrapping.
- R8: After an erroneous word, the next expectation is one more than the value held by a strict majority of the three lanes. If no two lanes agree, it is one more than the previous expectation.
- R9: `clr` is synchronous. It zeroes both counters and the trigger and forces re-seeding, and it wins over a valid word in the same cycle.
- R10: The active-low synchronous reset `rst_n` puts the block in the same state as `clr`.
- R11: The companion generator, while enabled, emits one valid word per cycle in the R1 layout with a count that steps by one and wraps. A checker fed only by it reports no errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of counters and lock |
| rx_word | input | 28 | Received parallel word |
| rx_valid | input | 1 | Qualifies `rx_word` this cycle |
| err_pulse | output | 1 | One-cycle trigger per erroneous word |
| err_count | output | CNT_W | Saturating erroneous-word count |
| word_count | output | CNT_W | Saturating valid-word count |

## Verification
The hardest states to reach are counter saturation and the three re-alignment outcomes of R8, which never occur on a clean link. The bench builds the counters with a narrow width so that a few hundred deliberately wrong words drive both to all ones. The lane-vote cases come from crafted table words: one lane damaged, a top bit set, the whole stream jumping, and all three lanes disagreeing. In each case the word that follows shows whether the expectation landed where the rule says.

// File: rtl/lnk_chk_pkg.sv
// Shared layout constants and types for the link pattern checker.
// Assumes the three count lanes sit contiguously from bit 0 upward.
package lnk_chk_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 3;
    localparam int WORD_W     = 28;
    localparam int USED_W     = FIELD_W * NUM_FIELDS;
    localparam int PAD_W      = WORD_W - USED_W;

    typedef logic [FIELD_W-1:0] cnt_t;
    typedef logic [WORD_W-1:0]  word_t;

    // Places one count value into every lane and leaves the pad bits at zero.
    function automatic word_t pack_word(cnt_t c);
        word_t w;
        w = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            w[i*FIELD_W +: FIELD_W] = c;
        end
        return w;
    endfunction
endpackage

// File: rtl/lnk_pat_gen.sv
// Transmit-side generator of the counting pattern.
// Emits one registered word per enabled cycle; the count wraps naturally.
module lnk_pat_gen
    import lnk_chk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    output word_t tx_word,
    output logic  tx_valid
);
    cnt_t cnt_q;

    // Step the count and register the outgoing word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tx_word  <= '0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= en;
            if (en) begin
                tx_word <= pack_word(cnt_q);
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // R11: every emitted valid word has its top pad bits clear.
    p_pad_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_word[WORD_W-1:USED_W] == '0));
endmodule

// File: rtl/lnk_field_cmp.sv
// Combinational lane comparator and majority voter.
// Assumes exp_cnt is the prediction for the word presented on word_in.
module lnk_field_cmp
    import lnk_chk_pkg::*;
(
    input  word_t word_in,
    input  cnt_t  exp_cnt,
    output logic  mismatch,
    output cnt_t  resync_cnt
);
    cnt_t                  fld [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fld_ok;
    logic                  pad_ok;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_lane
        assign fld[g]    = word_in[g*FIELD_W +: FIELD_W];
        assign fld_ok[g] = (fld[g] == exp_cnt);
    end

    assign pad_ok   = (word_in[WORD_W-1:USED_W] == '0);
    assign mismatch = !(&fld_ok) || !pad_ok;

    // Pick the first lane value held by a strict majority, else keep the prediction.
    always_comb begin
        int  agree;
        logic found;
        resync_cnt = exp_cnt;
        found      = 1'b0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            agree = 0;
            for (int j = 0; j < NUM_FIELDS; j++) begin
                if (fld[j] == fld[i]) agree++;
            end
            if (!found && (agree * 2 > NUM_FIELDS)) begin
                resync_cnt = fld[i];
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lnk_sat_cnt.sv
// Saturating event counter with synchronous clear.
// Assumes inc is a single-cycle qualifier; holds at all ones.
module lnk_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count qualified events, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc && (q != '1)) begin
            q <= q + 1'b1;
        end
    end

    // R6 / R7: a full counter never wraps back to zero.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q == '1 && !clr) |=> (q == '1));
endmodule

// File: rtl/lnk_err_chk.sv
// Counting-pattern error checker for a 28-bit parallel link.
// Seeds on the first valid word, predicts each next word, pulses on
// mismatch and re-aligns by lane majority. Assumes one word per clock.
module lnk_err_chk
    import lnk_chk_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WORD_W-1:0] rx_word,
    input  logic             rx_valid,
    output logic             err_pulse,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] word_count
);
    logic seeded;
    cnt_t exp_q;
    logic mismatch;
    cnt_t resync_cnt;
    logic take;
    logic chk_err;

    assign take    = rx_valid && !clr;
    assign chk_err = take && seeded && mismatch;

    lnk_field_cmp u_cmp (
        .word_in    (rx_word),
        .exp_cnt    (exp_q),
        .mismatch   (mismatch),
        .resync_cnt (resync_cnt)
    );

    // Track lock state, the next expected count and the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seeded    <= 1'b0;
            exp_q     <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= chk_err;
            if (take) begin
                seeded <= 1'b1;
                if (!seeded)       exp_q <= cnt_t'(rx_word[FIELD_W-1:0] + 1'b1);
                else if (mismatch) exp_q <= cnt_t'(resync_cnt + 1'b1);
                else               exp_q <= cnt_t'(exp_q + 1'b1);
            end
        end
    end

    lnk_sat_cnt #(.W(CNT_W)) u_err_cnt (
        .clk (clk), .rst_n (rst_n), .clr (clr), .inc (chk_err), .q (err_count)
    );

    lnk_sat_cnt #(.W(CNT_W)) u_word_cnt (
        .clk (clk), .rst_n (rst_n), .clr (clr), .inc (take), .q (word_count)
    );

    // R2: a word seen while unlocked never raises the trigger.
    p_no_pulse_unseeded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(seeded) |-> !err_pulse);

    // R5: a trigger only follows a valid, uncleared word.
    p_pulse_needs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(rx_valid && !clr));

    // R6: each trigger is matched by one error-count step unless saturated.
    p_pulse_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && ($past(err_count) != '1)) |-> (err_count == $past(err_count) + 1'b1));

    // R4: an idle cycle leaves the word count and trigger quiet.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !clr) |=> ($stable(word_count) && !err_pulse));

    // R9: clear empties both counters and the trigger.
    p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (err_count == '0 && word_count == '0 && !err_pulse));
endmodule

// File: tb/tb_lnk_err_chk.sv
module tb_lnk_err_chk;
    localparam int CW = 9;
    localparam int NV = 18;

    function automatic logic [27:0] mk(logic [7:0] c);
        return {4'h0, c, c, c};
    endfunction

    localparam logic [27:0] T_WORD [NV] = '{
        mk(8'd250), mk(8'd251), mk(8'd0), mk(8'd252), mk(8'd253), mk(8'd254),
        mk(8'd255), mk(8'd0), mk(8'd1) ^ 28'h0010000, mk(8'd2),
        mk(8'd3) | 28'h8000000, mk(8'd4), mk(8'd100), mk(8'd101),
        28'h0070966, mk(8'd103), 28'h0686805, mk(8'd105)};
    localparam bit T_VAL   [NV] = '{1,1,0,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1};
    localparam bit T_PULSE [NV] = '{0,0,0,0,0,0,0,0,1,0,1,0,1,0,1,0,1,0};
    localparam int T_ERR   [NV] = '{0,0,0,0,0,0,0,0,1,1,2,2,3,3,4,4,5,5};
    localparam int T_WC    [NV] = '{1,2,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17};
    localparam string T_REQ [NV] = '{"R2","R3","R4","R4","R3","R3","R3","R3",
        "R1","R8","R1","R8","R5","R8","R5","R8","R5","R8"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_clr = 1'b0;
    logic [27:0] drv_word = '0;
    logic drv_valid = 1'b0;
    logic use_gen = 1'b0;
    logic gen_en = 1'b0;
    logic [27:0] gen_word;
    logic gen_valid;
    logic [27:0] rx_word;
    logic rx_valid;
    logic err_pulse;
    logic [CW-1:0] err_count, word_count;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign rx_word  = use_gen ? gen_word  : drv_word;
    assign rx_valid = use_gen ? gen_valid : drv_valid;

    lnk_pat_gen gen (.clk(clk), .rst_n(rst_n), .en(gen_en),
                     .tx_word(gen_word), .tx_valid(gen_valid));

    lnk_err_chk #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .clr(drv_clr), .rx_word(rx_word),
        .rx_valid(rx_valid), .err_pulse(err_pulse),
        .err_count(err_count), .word_count(word_count));

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(logic [27:0] w, logic v, logic c);
        @(negedge clk);
        drv_word = w; drv_valid = v; drv_clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_state(string req, logic p, int e, int wc);
        check(req, "err_pulse", longint'(err_pulse), longint'(p));
        check(req, "err_count", longint'(err_count), longint'(e));
        check(req, "word_count", longint'(word_count), longint'(wc));
    endtask

    initial begin
        repeat (5) step('0, 1'b0, 1'b0);
        // R10: reset state
        expect_state("R10", 1'b0, 0, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(T_WORD[i], T_VAL[i], 1'b0);
            expect_state(T_REQ[i], T_PULSE[i], T_ERR[i], T_WC[i]);
        end

        // R9: clear wins over a valid word in the same cycle
        step(mk(8'd50), 1'b1, 1'b1);
        expect_state("R9", 1'b0, 0, 0);
        step(mk(8'd9), 1'b1, 1'b0);
        expect_state("R2", 1'b0, 0, 1);
        step(mk(8'd11), 1'b1, 1'b0);
        expect_state("R5", 1'b1, 1, 2);

        // R10: reset mid-stream, then re-seed on an arbitrary word
        @(negedge clk); rst_n = 1'b0;
        step(mk(8'd12), 1'b0, 1'b0);
        expect_state("R10", 1'b0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        step(mk(8'd77), 1'b1, 1'b0);
        expect_state("R10", 1'b0, 0, 1);

        // R11: generator stream is clean
        step('0, 1'b0, 1'b1);
        @(negedge clk); drv_clr = 1'b0; use_gen = 1'b1; gen_en = 1'b1;
        repeat (200) @(negedge clk);
        gen_en = 1'b0;
        repeat (3) @(negedge clk);
        expect_state("R11", 1'b0, 0, 200);
        use_gen = 1'b0;

        // R6 / R7: saturation under a stuck stream
        step('0, 1'b0, 1'b1);
        step(mk(8'd0), 1'b1, 1'b0);
        for (int k = 0; k < 600; k++) step(mk(8'd0), 1'b1, 1'b0);
        check("R6", "err_count saturated", longint'(err_count), 511);
        check("R7", "word_count saturated", longint'(word_count), 511);
        check("R5", "pulse on stuck word", longint'(err_pulse), 1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule